// File: doc/BRIEF.md
# Sequential SRAM Sample Buffer Controller

This block buffers a stream of 16-bit samples in an external asynchronous SRAM that is 16 bits wide, and hands the stored data to a slow host one byte at a time. Time is divided into fixed frames of `PERIOD` clock cycles, one frame per sample period. Each frame opens with a reserved write window. A sample captured during the previous frame is committed there. The rest of the frame is available for read slots. A read slot fetches the word at the current read position into an output register.

Both the write side and the read side address the memory strictly in sequence. A word counter tracks the write position. A byte counter tracks the read position: its upper bits give the word address and its lowest bit picks the byte shown to the host. A multiplexer puts one of the two addresses on the SRAM address bus. The host sees a data-available flag. It takes the byte and pulses an acknowledge, which advances the byte counter and schedules a fresh fetch. Chip select is held asserted at all times, and only write-enable and output-enable are sequenced.

Top module: `ssb_ctrl`

## Requirements
- R1: A sample presented on `sample_valid_i` is written in the next frame's write window. Counting frame positions from 0 at the first cycle after reset release, `sram_we_no` is low at positions 1..WE_LEN. Address, data and `sram_dq_oe_o` are held over positions 0..WE_LEN+1.
- R2: `sram_we_no` is low only at frame positions 1..WE_LEN. `sram_dq_oe_o` is high only at positions below WE_LEN+2. Write-enable, output-enable and the bus driver never overlap.
- R3: Each accepted sample is stored at the next word address, starting at word 0 after reset and wrapping modulo 2^AW.
- R4: A read slot holds `sram_oe_no` low for exactly RD_LEN consecutive cycles. The whole slot lies in frame positions WE_LEN+2..PERIOD-1.
- R5: When `host_avail_o` is high, `host_byte_o` shows bits 7:0 of the fetched word if the read byte counter is even, and bits 15:8 if it is odd. The first byte after reset is the low byte of word 0.
- R6: An acknowledge while `host_avail_o` is high advances the read byte counter by one and drops `host_avail_o` on the next cycle. An acknowledge while it is low has no effect.
- R7: While the read word address equals the write word address, the buffer is empty. No read slot starts and `host_avail_o` stays low.
- R8: A sample whose write would make the write word address equal to the read word address is dropped. No write-enable pulse occurs in that frame, and `overflow_o` rises and stays high until reset.
- R9: A sample that arrives while an earlier one is still waiting for its window replaces the waiting one.
- R10: While in reset, `host_avail_o` and `overflow_o` are low, `sram_we_no` and `sram_oe_no` are high, `sram_dq_oe_o` is low and `sram_ce_no` is low.
- R11: While `host_avail_o` is high and no acknowledge is given, `host_avail_o` and `host_byte_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe for a new sample |
| sample_i | input | 16 | Sample word |
| sram_addr_o | output | AW | SRAM word address |
| sram_dq_o | output | 16 | Data driven toward the SRAM |
| sram_dq_oe_o | output | 1 | Enable of the external data bus driver |
| sram_dq_i | input | 16 | Data returned by the SRAM |
| sram_ce_no | output | 1 | Chip select, always asserted (low) |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| host_byte_o | output | 8 | Byte presented to the host |
| host_avail_o | output | 1 | Byte is valid and waiting |
| host_ack_i | input | 1 | Host has taken the byte |
| overflow_o | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench targets the ring boundary. It fills the buffer until the eighth sample must be refused. A design that compares the addresses off by one would either overwrite the unread word, which shows up as corrupted read data, or refuse a sample too early, which shows up as a missing write pulse. It sends two samples within one frame, which catches a holding register that keeps the older sample or writes both. It also gives an acknowledge while nothing is available, which exposes a read counter that advances anyway through a shifted byte stream. Every strobe is compared cycle by cycle against the frame position computed from the cycle count, so a read slot that spills into the write window, or one of the wrong length, is reported where it occurs.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef logic [15:0] word_t;
  typedef logic [7:0]  byte_t;
endpackage

// File: rtl/ssb_slot_timer.sv
module ssb_slot_timer #(
  parameter int PERIOD = 240,
  parameter int WE_LEN = 2,
  parameter int RD_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic decide_o,
  output logic wr_last_o,
  output logic we_phase_o,
  output logic rd_ok_o
);
  localparam int FW = $clog2(PERIOD);
  localparam int WLEN = WE_LEN + 2;
  localparam logic [FW-1:0] FRM_LAST = FW'(PERIOD - 1);
  localparam logic [FW-1:0] WR_LAST  = FW'(WLEN - 1);
  localparam logic [FW-1:0] WE_END   = FW'(WE_LEN);
  localparam logic [FW-1:0] RD_LATE  = FW'(PERIOD - 1 - RD_LEN);

  logic [FW-1:0] frm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frm_q <= '0;
    else         frm_q <= (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
  end

  assign decide_o   = (frm_q == FRM_LAST);
  assign wr_last_o  = (frm_q == WR_LAST);
  assign we_phase_o = (frm_q != '0) && (frm_q <= WE_END);
  // a slot started here ends no later than the last frame position
  assign rd_ok_o    = (frm_q >= WR_LAST) && (frm_q <= RD_LATE);
endmodule

// File: rtl/ssb_write_path.sv
module ssb_write_path
  import ssb_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  word_t         sample_i,
  input  logic          decide_i,
  input  logic          wr_last_i,
  input  logic [AW-1:0] rd_word_i,
  output logic          wr_act_o,
  output logic [AW-1:0] wr_ptr_o,
  output word_t         wr_data_o,
  output logic          overflow_o
);
  logic          pend_q, wr_act_q, ovf_q;
  word_t         pend_data_q, wr_data_q;
  logic [AW-1:0] wr_ptr_q;
  logic          full;

  assign full = (AW'(wr_ptr_q + 1'b1) == rd_word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      wr_act_q    <= 1'b0;
      wr_data_q   <= '0;
      wr_ptr_q    <= '0;
      ovf_q       <= 1'b0;
    end else begin
      if (decide_i) begin
        wr_act_q  <= pend_q && !full;
        wr_data_q <= pend_data_q;
        if (pend_q && full) ovf_q <= 1'b1;
      end else if (wr_last_i) begin
        wr_act_q <= 1'b0;
      end
      if (wr_last_i && wr_act_q) wr_ptr_q <= wr_ptr_q + 1'b1;
      // newest sample wins the holding register
      if (sample_valid_i) begin
        pend_q      <= 1'b1;
        pend_data_q <= sample_i;
      end else if (decide_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign wr_act_o   = wr_act_q;
  assign wr_ptr_o   = wr_ptr_q;
  assign wr_data_o  = wr_data_q;
  assign overflow_o = ovf_q;

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_wr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_ptr_q) |-> (wr_ptr_q == AW'($past(wr_ptr_q) + 1'b1)));
  p_no_catch_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_ptr_q) |-> (wr_ptr_q != rd_word_i));
endmodule

// File: rtl/ssb_read_path.sv
module ssb_read_path
  import ssb_pkg::*;
#(
  parameter int AW     = 15,
  parameter int RD_LEN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_ok_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  word_t         dq_i,
  input  logic          ack_i,
  output logic          rd_act_o,
  output logic [AW-1:0] rd_word_o,
  output byte_t         byte_o,
  output logic          avail_o
);
  localparam int PW = $clog2(RD_LEN + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(RD_LEN - 1);

  logic [AW:0]   rd_cnt_q;
  logic          rd_act_q, avail_q;
  logic [PW-1:0] ph_q;
  word_t         rword_q;
  logic          empty, start;

  assign empty = (rd_cnt_q[AW:1] == wr_ptr_i);
  assign start = !rd_act_q && !avail_q && !empty && rd_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      rd_act_q <= 1'b0;
      avail_q  <= 1'b0;
      ph_q     <= '0;
      rword_q  <= '0;
    end else begin
      if (start) begin
        rd_act_q <= 1'b1;
        ph_q     <= '0;
      end else if (rd_act_q) begin
        if (ph_q == PH_LAST) begin
          rd_act_q <= 1'b0;
          rword_q  <= dq_i;
          avail_q  <= 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
      if (avail_q && ack_i) begin
        avail_q  <= 1'b0;
        rd_cnt_q <= rd_cnt_q + 1'b1;
      end
    end
  end

  assign rd_act_o  = rd_act_q;
  assign rd_word_o = rd_cnt_q[AW:1];
  assign byte_o    = rd_cnt_q[0] ? rword_q[15:8] : rword_q[7:0];
  assign avail_o   = avail_q;

  p_rd_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act_q |-> (rd_cnt_q[AW:1] != wr_ptr_i));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_q && !ack_i) |=> (avail_q && $stable(byte_o)));
  p_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_q && ack_i) |=> (!avail_q && rd_cnt_q == (AW+1)'($past(rd_cnt_q) + 1'b1)));
  p_ack_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_q |=> $stable(rd_cnt_q));
endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int PERIOD = 240,
  parameter int AW     = 15,
  parameter int WE_LEN = 2,
  parameter int RD_LEN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  logic [15:0]   sample_i,
  output logic [AW-1:0] sram_addr_o,
  output logic [15:0]   sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [15:0]   sram_dq_i,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic [7:0]    host_byte_o,
  output logic          host_avail_o,
  input  logic          host_ack_i,
  output logic          overflow_o
);
  logic          decide, wr_last, we_phase, rd_ok;
  logic          wr_act, rd_act;
  logic [AW-1:0] wr_ptr, rd_word;
  word_t         wr_data;

  ssb_slot_timer #(.PERIOD(PERIOD), .WE_LEN(WE_LEN), .RD_LEN(RD_LEN)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .decide_o(decide), .wr_last_o(wr_last), .we_phase_o(we_phase), .rd_ok_o(rd_ok)
  );

  ssb_write_path #(.AW(AW)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sample_valid_i(sample_valid_i), .sample_i(sample_i),
    .decide_i(decide), .wr_last_i(wr_last), .rd_word_i(rd_word),
    .wr_act_o(wr_act), .wr_ptr_o(wr_ptr), .wr_data_o(wr_data), .overflow_o(overflow_o)
  );

  ssb_read_path #(.AW(AW), .RD_LEN(RD_LEN)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_ok_i(rd_ok), .wr_ptr_i(wr_ptr), .dq_i(sram_dq_i), .ack_i(host_ack_i),
    .rd_act_o(rd_act), .rd_word_o(rd_word), .byte_o(host_byte_o), .avail_o(host_avail_o)
  );

  assign sram_addr_o  = wr_act ? wr_ptr : rd_word;
  assign sram_dq_o    = wr_data;
  assign sram_dq_oe_o = wr_act;
  assign sram_ce_no   = 1'b0;
  assign sram_we_no   = !(wr_act && we_phase);
  assign sram_oe_no   = !rd_act;

  p_strobe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));
  p_bus_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);
  p_we_driven_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_dq_oe_o && $stable(sram_addr_o) && $stable(sram_dq_o)));
endmodule

// File: tb/sim_ssb_ctrl.sv
module sim_ssb_ctrl;
  localparam int P = 24, AW = 3, WEL = 2, RDL = 3;
  localparam int WLEN = WEL + 2, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sv = 1'b0, ack = 1'b0;
  logic [15:0] sd = '0;
  logic [AW-1:0] addr;
  logic [15:0] dq_o, dq_i;
  logic dq_oe, ce_n, we_n, oe_n, avail, ovf;
  logic [7:0] hbyte;

  ssb_ctrl #(.PERIOD(P), .AW(AW), .WE_LEN(WEL), .RD_LEN(RDL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv), .sample_i(sd),
    .sram_addr_o(addr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n),
    .host_byte_o(hbyte), .host_avail_o(avail), .host_ack_i(ack), .overflow_o(ovf)
  );

  logic [15:0] mem [DEPTH];
  always @(posedge clk) if (!we_n && dq_oe) mem[addr] <= dq_o;
  assign dq_i = !oe_n ? mem[addr] : 16'hDEAD;

  int cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int we_pulses = 0, oe_run = 0;
  logic we_prev = 1'b1;
  always @(negedge clk) begin : mon
    int f;
    if (rst_n) begin
      f = cyc % P;
      if (!we_n) chk(f >= 1 && f <= WEL, "R2 we window", f, 1);
      if (dq_oe) chk(f < WLEN && oe_n, "R2 bus drive", f, 0);
      if (!oe_n) begin
        chk(f >= WLEN && we_n, "R4 oe window", f, WLEN);
        oe_run++;
      end else if (oe_run != 0) begin
        chk(oe_run == RDL, "R4 oe length", oe_run, RDL);
        oe_run = 0;
      end
      if (!we_n && we_prev) we_pulses++;
      we_prev = we_n;
    end
  end

  function automatic logic [15:0] smp(input int k);
    return 16'((k + 1) * 4951) ^ 16'(k * 256);
  endfunction

  logic [15:0] exp_q[$];
  int wr_idx = 0;

  task automatic wait_pos(input int pos);
    while (cyc % P != pos) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] d);
    wait_pos(P / 2);
    sv = 1'b1; sd = d;
    @(negedge clk);
    sv = 1'b0;
  endtask

  task automatic put(input logic [15:0] d);
    int p;
    p = we_pulses;
    send(d);
    wait_pos(WLEN + 1);
    chk(we_pulses == p + 1, "R1 write pulse", we_pulses, p + 1);
    chk(mem[wr_idx % DEPTH] == d, "R3 stored word", mem[wr_idx % DEPTH], d);
    wr_idx++;
    exp_q.push_back(d);
  endtask

  task automatic host_read(input logic [7:0] e, input string req);
    while (!avail) @(negedge clk);
    chk(hbyte == e, req, hbyte, e);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(!avail, "R6 avail drop", avail, 0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin
      logic [15:0] w;
      w = exp_q.pop_front();
      host_read(w[7:0], "R5 low byte");
      host_read(w[15:8], "R5 high byte");
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!avail, "R10 avail", avail, 0);
    chk(!ovf, "R10 overflow", ovf, 0);
    chk(we_n && oe_n, "R10 strobes", {we_n, oe_n}, 3);
    chk(!dq_oe, "R10 bus", dq_oe, 0);
    chk(!ce_n, "R10 chip select", ce_n, 0);
    rst_n = 1'b1;

    // R7 empty buffer: no read slots, nothing available
    begin
      int seen;
      seen = 0;
      repeat (3 * P) begin
        @(negedge clk);
        if (!oe_n || avail) seen++;
      end
      chk(seen == 0, "R7 empty idle", seen, 0);
    end

    for (int k = 0; k < 5; k++) put(smp(k));
    drain();

    // fill to capacity: seven words fit with read word at 5
    for (int k = 5; k < 12; k++) begin
      put(smp(k));
      chk(!ovf, "R8 no early overflow", ovf, 0);
    end
    begin
      int p;
      p = we_pulses;
      send(smp(99));
      wait_pos(WLEN + 1);
      chk(we_pulses == p, "R8 dropped write", we_pulses, p);
      chk(ovf, "R8 overflow set", ovf, 1);
    end

    // R11 hold without ack
    begin
      logic [7:0] b;
      int bad;
      while (!avail) @(negedge clk);
      b = hbyte;
      bad = 0;
      repeat (2 * P) begin
        @(negedge clk);
        if (!avail || hbyte != b) bad++;
      end
      chk(bad == 0, "R11 hold", bad, 0);
    end
    drain();
    chk(ovf, "R8 overflow sticky", ovf, 1);

    // R9 two samples in one frame: newer replaces older
    begin
      int p;
      p = we_pulses;
      wait_pos(P / 2);
      sv = 1'b1; sd = 16'h1111;
      @(negedge clk); sv = 1'b0;
      @(negedge clk); sv = 1'b1; sd = 16'h2BCD;
      @(negedge clk); sv = 1'b0;
      wait_pos(WLEN + 1);
      chk(we_pulses == p + 1, "R9 single write", we_pulses, p + 1);
      chk(mem[wr_idx % DEPTH] == 16'h2BCD, "R9 newer kept", mem[wr_idx % DEPTH], 16'h2BCD);
      wr_idx++;
      exp_q.push_back(16'h2BCD);
    end
    drain();

    // R6 ack with nothing available must not move the read position
    ack = 1'b1;
    repeat (3) @(negedge clk);
    ack = 1'b0;
    chk(!avail, "R6 idle ack", avail, 0);
    put(16'h5A3C);
    drain();

    summary();
    $finish;
  end
endmodule